// File: doc/BRIEF.md
# DAC Register Front-End with Scheduled Update

This block sits between a CPU byte bus and a 12-bit digital-to-analog converter. Software writes the converter value as two bytes, a low and a high data register, and sets a control register. The control register picks the update trigger and the position of the 12-bit word inside the 16-bit register pair. The converter input latch then loads on one of two kinds of event. The first is a write to the high data byte. The second is a single-cycle overflow pulse from one of three timers. The timers and the analog converter are outside this block.

The data registers act as a holding stage. The latch is driven only by a commit event. When the latch loads, the 16-bit pair is shifted right by the amount that the justification code selects. The low 12 bits of that result become the converter value. This lets software place its sample anywhere from fully right-aligned to fully left-aligned, with no shift instructions. A waveform whose sample rate is set by a timer is free of interrupt latency, because the CPU only has to fill the holding registers before the next overflow.

Top module: `dac_frontend`

## Requirements
- R1: After reset, the low data, high data and control registers all read as zero, and `dac_code` is zero.
- R2: Register addresses are 0 for the low data byte, 1 for the high data byte and 2 for control. Control keeps only bits [4:0]; its bits [7:5] read as 0. Address 3 reads 0. `bus_rdata` shows the addressed register combinationally, and reading changes no state.
- R3: In update mode 00 (control bits [4:3]), a write to address 1 commits the word {written high byte, held low byte} to the latch. The new value appears on `dac_code` from the clock edge that takes the write.
- R4: In update mode 00, a write to address 0 leaves `dac_code` unchanged.
- R5: In mode 01, a pulse on `ovf_sel1` commits {high, low}. Mode 10 uses `ovf_sel2` in the same way, and mode 11 uses `ovf_sel3`. In these three modes, writes to either data byte leave `dac_code` unchanged.
- R6: An overflow pulse on a line that the current mode does not select leaves `dac_code` unchanged. In mode 00 this applies to all three lines.
- R7: The justification code is control bits [2:0]. On commit, `dac_code` = bits [s+11:s] of {high, low}. Code 000 gives s=0, code 001 gives s=1, code 010 gives s=2 and code 011 gives s=3. Any code 1xx gives s=4. Bits outside this window have no effect.
- R8: If a data write falls in the same cycle as a commit event, the word that is committed already contains the written byte.
- R9: A commit uses the justification code that the control register held before the commit cycle. A control write in that same cycle takes effect only for later commits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Byte write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register |
| ovf_sel1 | input | 1 | Overflow pulse used by mode 01 |
| ovf_sel2 | input | 1 | Overflow pulse used by mode 10 |
| ovf_sel3 | input | 1 | Overflow pulse used by mode 11 |
| dac_code | output | 12 | Latched converter value |

## Verification
The bench builds the block with its default parameters: an 8-bit byte and a 12-bit converter word, which leaves a 4-bit justification range. At this size every one of the eight justification codes can be swept against several bit patterns, and every combination of the four update modes with the three overflow lines can be tried. A reference value for each step is computed arithmetically in the bench, by shifting the 16-bit pair right and masking to 12 bits. The same-cycle collisions of a write with a commit, and of a control write with a commit, are driven explicitly.

// File: rtl/dac_fe_pkg.sv
// Shared definitions for the DAC front-end: register addresses and update modes.
package dac_fe_pkg;

    localparam logic [1:0] ADDR_LO   = 2'd0;
    localparam logic [1:0] ADDR_HI   = 2'd1;
    localparam logic [1:0] ADDR_CTRL = 2'd2;

    localparam int CTRL_W = 5;

    typedef enum logic [1:0] {
        UPD_ON_WRITE = 2'b00,
        UPD_SRC1     = 2'b01,
        UPD_SRC2     = 2'b10,
        UPD_SRC3     = 2'b11
    } upd_mode_e;

endpackage

// File: rtl/dac_fe_regs.sv
// Holding registers (low byte, high byte, control) with read mux.
// Assumes single-byte writes; exposes next-state values so a same-cycle
// write can be folded into a commit.
module dac_fe_regs
    import dac_fe_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  logic [1:0]          addr,
    input  logic [BYTE_W-1:0]   wdata,
    output logic [BYTE_W-1:0]   rdata,
    output logic [BYTE_W-1:0]   lo_q,
    output logic [BYTE_W-1:0]   hi_q,
    output logic [CTRL_W-1:0]   ctrl_q,
    output logic [BYTE_W-1:0]   lo_nx,
    output logic [BYTE_W-1:0]   hi_nx
);

    // Next-state values of the data bytes, including this cycle's write.
    always_comb begin
        lo_nx = (wr && addr == ADDR_LO) ? wdata : lo_q;
        hi_nx = (wr && addr == ADDR_HI) ? wdata : hi_q;
    end

    // Register update with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q   <= '0;
            hi_q   <= '0;
            ctrl_q <= '0;
        end else begin
            lo_q <= lo_nx;
            hi_q <= hi_nx;
            if (wr && addr == ADDR_CTRL)
                ctrl_q <= wdata[CTRL_W-1:0];
        end
    end

    // Side-effect-free read mux.
    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_LO:   rdata = lo_q;
            ADDR_HI:   rdata = hi_q;
            ADDR_CTRL: rdata[CTRL_W-1:0] = ctrl_q;
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/dac_fe_trigger.sv
// Commit-event selection: a high-byte write in mode 00, otherwise the
// overflow pulse picked by the mode. Assumes pulses last one cycle.
module dac_fe_trigger
    import dac_fe_pkg::*;
(
    input  upd_mode_e   mode,
    input  logic        hi_write,
    input  logic [2:0]  ovf,
    output logic        commit
);

    // Pick the trigger source for the current mode.
    always_comb begin
        unique case (mode)
            UPD_ON_WRITE: commit = hi_write;
            UPD_SRC1:     commit = ovf[0];
            UPD_SRC2:     commit = ovf[1];
            UPD_SRC3:     commit = ovf[2];
            default:      commit = 1'b0;
        endcase
    end

endmodule

// File: rtl/dac_fe_align.sv
// Justification: selects a DAC_W-bit window of the 2*BYTE_W pair.
// Codes 0..3 shift right by the code (clamped), codes with bit 2 set use
// the widest shift. Assumes DAC_W <= 2*BYTE_W.
module dac_fe_align #(
    parameter int BYTE_W = 8,
    parameter int DAC_W  = 12
) (
    input  logic [2*BYTE_W-1:0] word,
    input  logic [2:0]          code,
    output logic [DAC_W-1:0]    value
);

    localparam int MAXSH = 2 * BYTE_W - DAC_W;

    logic [DAC_W-1:0] cand [MAXSH+1];

    // One candidate window per possible shift.
    for (genvar s = 0; s <= MAXSH; s++) begin : g_win
        assign cand[s] = word[s +: DAC_W];
    end

    // Map the code to a shift and select that window.
    always_comb begin
        int sh;
        sh = code[2] ? MAXSH : int'(code[1:0]);
        if (sh > MAXSH)
            sh = MAXSH;
        value = cand[sh];
    end

endmodule

// File: rtl/dac_frontend.sv
// DAC register front-end: holding registers, commit selection, justification
// and the converter input latch. Synchronous active-low reset.
module dac_frontend
    import dac_fe_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int DAC_W  = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [1:0]         bus_addr,
    input  logic [BYTE_W-1:0]  bus_wdata,
    output logic [BYTE_W-1:0]  bus_rdata,
    input  logic               ovf_sel1,
    input  logic               ovf_sel2,
    input  logic               ovf_sel3,
    output logic [DAC_W-1:0]   dac_code
);

    logic [BYTE_W-1:0] lo_q, hi_q, lo_nx, hi_nx;
    logic [CTRL_W-1:0] ctrl_q;
    logic              commit;
    logic [DAC_W-1:0]  aligned;
    upd_mode_e         mode;

    assign mode = upd_mode_e'(ctrl_q[4:3]);

    dac_fe_regs #(.BYTE_W(BYTE_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (bus_wr),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .rdata  (bus_rdata),
        .lo_q   (lo_q),
        .hi_q   (hi_q),
        .ctrl_q (ctrl_q),
        .lo_nx  (lo_nx),
        .hi_nx  (hi_nx)
    );

    dac_fe_trigger u_trig (
        .mode     (mode),
        .hi_write (bus_wr && bus_addr == ADDR_HI),
        .ovf      ({ovf_sel3, ovf_sel2, ovf_sel1}),
        .commit   (commit)
    );

    dac_fe_align #(.BYTE_W(BYTE_W), .DAC_W(DAC_W)) u_align (
        .word  ({hi_nx, lo_nx}),
        .code  (ctrl_q[2:0]),
        .value (aligned)
    );

    // Converter input latch: loads the justified word on a commit event.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dac_code <= '0;
        else if (commit)
            dac_code <= aligned;
    end

endmodule

// File: rtl/dac_frontend_checker.sv
// Temporal checks on the DAC front-end, bound to every instance of the top.
module dac_frontend_checker #(
    parameter int BYTE_W = 8,
    parameter int DAC_W  = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [1:0]        bus_addr,
    input logic [BYTE_W-1:0] bus_wdata,
    input logic              ovf_sel1,
    input logic              ovf_sel2,
    input logic              ovf_sel3,
    input logic [DAC_W-1:0]  dac_code,
    input logic [BYTE_W-1:0] lo_q,
    input logic [4:0]        ctrl_q
);

    localparam int MAXSH = 2 * BYTE_W - DAC_W;

    logic [1:0] cmode;
    logic       sel_pulse, hi_wr, lo_wr, any_event;

    always_comb begin
        cmode = ctrl_q[4:3];
        hi_wr = bus_wr && bus_addr == 2'd1;
        lo_wr = bus_wr && bus_addr == 2'd0;
        case (cmode)
            2'd1:    sel_pulse = ovf_sel1;
            2'd2:    sel_pulse = ovf_sel2;
            2'd3:    sel_pulse = ovf_sel3;
            default: sel_pulse = 1'b0;
        endcase
        any_event = (cmode == 2'd0) ? hi_wr : sel_pulse;
    end

    // R4: a low-byte write in mode 00 leaves the output alone.
    assert_lo_write_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmode == 2'd0 && lo_wr) |=> $stable(dac_code));

    // R5 and R6: data writes and unselected pulses in timer modes leave the output alone.
    assert_timer_mode_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmode != 2'd0 && !sel_pulse) |=> $stable(dac_code));

    // R3: right-justified on-demand commit takes {written high, held low}.
    assert_demand_right_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmode == 2'd0 && ctrl_q[2:0] == 3'd0 && hi_wr)
        |=> dac_code == DAC_W'({$past(bus_wdata), $past(lo_q)}));

    // R7: left-justified codes take the top window.
    assert_left_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmode == 2'd0 && ctrl_q[2] && hi_wr)
        |=> dac_code == DAC_W'({$past(bus_wdata), $past(lo_q)} >> MAXSH));

    // R2: control writes keep the low five bits.
    assert_ctrl_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd2) |=> ctrl_q == $past(bus_wdata[4:0]));

    // R1 and R6: no output change without a commit event.
    assert_no_event_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !any_event |=> $stable(dac_code));

endmodule

bind dac_frontend dac_frontend_checker #(.BYTE_W(BYTE_W), .DAC_W(DAC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .ovf_sel1  (ovf_sel1),
    .ovf_sel2  (ovf_sel2),
    .ovf_sel3  (ovf_sel3),
    .dac_code  (dac_code),
    .lo_q      (lo_q),
    .ctrl_q    (ctrl_q)
);

// File: tb/dac_frontend_test.sv
// Self-checking sweep bench for dac_frontend at default parameters.
module dac_frontend_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        ovf_sel1 = 1'b0, ovf_sel2 = 1'b0, ovf_sel3 = 1'b0;
    logic [11:0] dac_code;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Bench-side model state.
    logic [7:0]  m_lo = '0, m_hi = '0;
    logic [4:0]  m_ctrl = '0;
    logic [11:0] m_dac = '0;

    always #10 clk = ~clk;

    dac_frontend uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ovf_sel1(ovf_sel1),
        .ovf_sel2(ovf_sel2), .ovf_sel3(ovf_sel3), .dac_code(dac_code)
    );

    function automatic logic [11:0] justify(logic [15:0] w, logic [2:0] c);
        int sh;
        sh = c[2] ? 4 : int'(c[1:0]);
        return 12'((w >> sh) & 16'h0FFF);
    endfunction

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One bus cycle with optional write and overflow pulses; updates the model
    // and checks dac_code after the edge.
    task automatic cyc(string tag, bit wr, logic [1:0] a, logic [7:0] d, logic [2:0] ovf);
        logic [7:0] lo_n, hi_n;
        bit fire;
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_wdata = d;
        {ovf_sel3, ovf_sel2, ovf_sel1} = ovf;
        lo_n = (wr && a == 2'd0) ? d : m_lo;
        hi_n = (wr && a == 2'd1) ? d : m_hi;
        case (m_ctrl[4:3])
            2'd0: fire = wr && a == 2'd1;
            2'd1: fire = ovf[0];
            2'd2: fire = ovf[1];
            default: fire = ovf[2];
        endcase
        if (fire) m_dac = justify({hi_n, lo_n}, m_ctrl[2:0]);
        m_lo = lo_n; m_hi = hi_n;
        if (wr && a == 2'd2) m_ctrl = d[4:0];
        @(negedge clk);
        bus_wr = 1'b0; {ovf_sel3, ovf_sel2, ovf_sel1} = 3'b000;
        check(tag, 16'(dac_code), 16'(m_dac));
    endtask

    task automatic rd(string tag, logic [1:0] a, logic [7:0] exp);
        bus_addr = a;
        #1;
        check(tag, 16'(bus_rdata), 16'(exp));
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] pats [6];
        pats[0] = 16'hFFFF; pats[1] = 16'h0000; pats[2] = 16'hA5C3;
        pats[3] = 16'h1234; pats[4] = 16'h8001; pats[5] = 16'h7FFE;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 dac", 16'(dac_code), 16'h0);
        rd("R1 lo", 2'd0, 8'h00);
        rd("R1 hi", 2'd1, 8'h00);
        rd("R1 ctrl", 2'd2, 8'h00);

        // R2: register map and readback
        cyc("R2 ctrl write", 1, 2'd2, 8'hFF, 3'b000);
        rd("R2 ctrl bits", 2'd2, 8'h1F);
        cyc("R2 ctrl clear", 1, 2'd2, 8'h00, 3'b000);
        rd("R2 ctrl zero", 2'd2, 8'h00);
        rd("R2 addr3", 2'd3, 8'h00);
        cyc("R4 lo write", 1, 2'd0, 8'hA5, 3'b000);
        rd("R2 lo read", 2'd0, 8'hA5);
        rd("R2 lo reread", 2'd0, 8'hA5);
        check("R2 read no effect", 16'(dac_code), 16'(m_dac));

        // R3 R4 R7: sweep justification codes and patterns in mode 00
        for (int c = 0; c < 8; c++) begin
            cyc("R7 set code", 1, 2'd2, 8'(c), 3'b000);
            for (int p = 0; p < 6; p++) begin
                cyc("R4 lo held", 1, 2'd0, pats[p][7:0], 3'b000);
                cyc("R3 R7 commit", 1, 2'd1, pats[p][15:8], 3'b000);
                rd("R2 hi read", 2'd1, pats[p][15:8]);
            end
            // R6: all overflow lines ignored in mode 00
            cyc("R6 mode00 pulses", 0, 2'd0, 8'h00, 3'b111);
        end

        // R5 R6: each timer mode against each overflow line
        for (int m = 1; m < 4; m++) begin
            for (int c = 0; c < 8; c += 3) begin
                cyc("R5 set mode", 1, 2'd2, 8'((m << 3) | c), 3'b000);
                cyc("R5 lo held", 1, 2'd0, 8'(8'h3C + m + c), 3'b000);
                cyc("R5 hi held", 1, 2'd1, 8'(8'hC1 ^ (m * 17 + c)), 3'b000);
                for (int p = 0; p < 3; p++)
                    cyc((p == m - 1) ? "R5 selected pulse" : "R6 unselected pulse",
                        0, 2'd0, 8'h00, 3'(1 << p));
            end
        end

        // R8: same-cycle data write and commit
        cyc("R8 set mode01", 1, 2'd2, 8'h08, 3'b000);
        cyc("R8 hi+pulse", 1, 2'd1, 8'h9E, 3'b001);
        cyc("R8 lo+pulse", 1, 2'd0, 8'h47, 3'b001);
        cyc("R8 set mode00 left", 1, 2'd2, 8'h04, 3'b000);
        cyc("R8 hi demand", 1, 2'd1, 8'h2B, 3'b000);

        // R9: control write in commit cycle affects only later commits
        cyc("R9 set mode10 code0", 1, 2'd2, 8'h10, 3'b000);
        cyc("R9 lo", 1, 2'd0, 8'hF3, 3'b000);
        cyc("R9 hi", 1, 2'd1, 8'h6D, 3'b000);
        cyc("R9 ctrl+pulse old code", 1, 2'd2, 8'h14, 3'b010);
        check("R9 old code value", 16'(dac_code), 16'(justify(16'h6DF3, 3'd0)));
        cyc("R9 pulse new code", 0, 2'd0, 8'h00, 3'b010);
        check("R9 new code value", 16'(dac_code), 16'(justify(16'h6DF3, 3'd4)));

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule